// File: doc/BRIEF.md
# Integer ALU Instruction Execute Unit

This block executes 32-bit integer arithmetic, bitwise logic and shift instructions against a private bank of 32 general registers. Each clock cycle it can take one instruction word, flagged valid. It decodes that word, reads up to two source registers, and produces a result through a shared adder/subtractor, a bitwise unit or a barrel shifter. It writes the result back on the same rising edge. Two kinds of instruction are blocked from writing: an instruction whose encoding is not recognised, and a trapping add or subtract whose signed result overflows. Each of these instead raises a one-cycle exception pulse that carries a cause code.

The block sits in the execute stage of a simple in-order core. A debug read port lets the surrounding logic, or a bench, observe any register without disturbing execution.

Top module: `int_exec_unit`

## Requirements
- R1: A synchronous active-low reset clears every register to zero and holds `exc_valid` low.
- R2: Register 0 always reads as zero. An instruction that names it as destination leaves it at zero and raises no exception of its own.
- R3: Register-form words have opcode bits [31:26] = 0, rs [25:21], rt [20:16], rd [15:11], shift amount [10:6] and function [5:0]. Functions 0x20 add, 0x21 addu, 0x22 sub and 0x23 subu write rs+rt or rs−rt modulo 2^32 to rd. addu and subu never raise an exception.
- R4: add, sub and addi whose true signed result lies outside −2^31..2^31−1 leave every register unchanged. In the cycle after the edge they raise `exc_valid` with `exc_code` = 1.
- R5: Functions 0x24, 0x25, 0x26 and 0x27 write rs AND rt, rs OR rt, rs XOR rt and NOT(rs OR rt) to rd.
- R6: Functions 0 (left logical), 2 (right logical) and 3 (right arithmetic) shift rt by the 5-bit shift field and write the result to rd. Logical shifts fill with zeros; the arithmetic shift fills with rt's sign bit.
- R7: Functions 4, 6 and 7 perform the same three shifts, with the amount taken from the low 5 bits of register rs.
- R8: Immediate-form words have opcode [31:26], rs [25:21], rt [20:16] as destination, and imm [15:0]. Opcodes 0x08 addi and 0x09 addiu add the sign-extended imm. Opcodes 0x0C, 0x0D and 0x0E AND, OR and XOR the zero-extended imm. Opcode 0x0F writes imm into bits [31:16] and zeros into bits [15:0].
- R9: Any other opcode, and any other function under opcode 0, writes nothing and raises `exc_valid` with `exc_code` = 2 in the following cycle.
- R10: With `insn_valid` low no register changes, and `exc_valid` is low in the following cycle.
- R11: `exc_valid` is high for exactly the one cycle after each faulting instruction. It is low after a non-faulting one, and whenever it is high `exc_code` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| insn_valid | input | 1 | Instruction word is to be executed this cycle |
| insn | input | 32 | Instruction word |
| exc_valid | output | 1 | One-cycle exception pulse for the previous instruction |
| exc_code | output | 2 | Cause: 0 none, 1 signed overflow, 2 reserved encoding |
| dbg_addr | input | 5 | Debug register select |
| dbg_data | output | 32 | Combinational contents of the selected register |

## Verification
The assertions assume that `insn` and `insn_valid` are stable and known at every rising edge once reset is released. They also assume that reset is held for at least one edge, so that the registers start from zero. The bench meets both conditions by changing inputs only just after an edge, and by keeping `insn_valid` low throughout reset and during every debug sweep. For the randomised mix it draws register numbers from a small window, so that results feed later instructions and the overflow corners recur.

// File: rtl/ixu_pkg.sv
// Shared types for the integer execute unit.
// Assumes a 32-bit instruction word with fixed field positions.
package ixu_pkg;

    typedef enum logic [3:0] {
        K_ADD, K_SUB, K_AND, K_OR, K_XOR, K_NOR, K_SLL, K_SRL, K_SRA, K_LUI
    } kind_t;

    typedef enum logic [1:0] {
        EXC_NONE = 2'd0,
        EXC_OVF  = 2'd1,
        EXC_RSVD = 2'd2
    } exc_t;

    typedef struct packed {
        kind_t kind;      // which datapath function drives the result
        logic  trap_ovf;  // signed overflow must fault
        logic  use_imm;   // second operand is the immediate
        logic  imm_sext;  // sign-extend (else zero-extend) the immediate
        logic  var_shamt; // shift amount from rs instead of the field
        logic  dst_rt;    // destination is rt (immediate form)
        logic  legal;     // encoding recognised
    } ctl_t;

endpackage

// File: rtl/ixu_decode.sv
// Instruction decoder: maps opcode and function fields to datapath controls.
// Purely combinational; any unlisted encoding comes out with legal = 0.
module ixu_decode
    import ixu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl
);

    // Decode table for register and immediate forms.
    always_comb begin
        ctl.kind      = K_ADD;
        ctl.trap_ovf  = 1'b0;
        ctl.use_imm   = 1'b0;
        ctl.imm_sext  = 1'b0;
        ctl.var_shamt = 1'b0;
        ctl.dst_rt    = 1'b0;
        ctl.legal     = 1'b1;
        case (opcode)
            6'h00: begin
                case (funct)
                    6'h00: ctl.kind = K_SLL;
                    6'h02: ctl.kind = K_SRL;
                    6'h03: ctl.kind = K_SRA;
                    6'h04: begin ctl.kind = K_SLL; ctl.var_shamt = 1'b1; end
                    6'h06: begin ctl.kind = K_SRL; ctl.var_shamt = 1'b1; end
                    6'h07: begin ctl.kind = K_SRA; ctl.var_shamt = 1'b1; end
                    6'h20: ctl.trap_ovf = 1'b1;
                    6'h21: ctl.kind = K_ADD;
                    6'h22: begin ctl.kind = K_SUB; ctl.trap_ovf = 1'b1; end
                    6'h23: ctl.kind = K_SUB;
                    6'h24: ctl.kind = K_AND;
                    6'h25: ctl.kind = K_OR;
                    6'h26: ctl.kind = K_XOR;
                    6'h27: ctl.kind = K_NOR;
                    default: ctl.legal = 1'b0;
                endcase
            end
            6'h08: begin ctl.use_imm = 1'b1; ctl.imm_sext = 1'b1; ctl.dst_rt = 1'b1; ctl.trap_ovf = 1'b1; end
            6'h09: begin ctl.use_imm = 1'b1; ctl.imm_sext = 1'b1; ctl.dst_rt = 1'b1; end
            6'h0C: begin ctl.kind = K_AND; ctl.use_imm = 1'b1; ctl.dst_rt = 1'b1; end
            6'h0D: begin ctl.kind = K_OR;  ctl.use_imm = 1'b1; ctl.dst_rt = 1'b1; end
            6'h0E: begin ctl.kind = K_XOR; ctl.use_imm = 1'b1; ctl.dst_rt = 1'b1; end
            6'h0F: begin ctl.kind = K_LUI; ctl.use_imm = 1'b1; ctl.dst_rt = 1'b1; end
            default: ctl.legal = 1'b0;
        endcase
    end

endmodule

// File: rtl/ixu_regfile.sv
// General register bank: two combinational operand reads, one debug read,
// one synchronous write. Entry 0 is never written, so it reads as zero.
module ixu_regfile #(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [AW-1:0]   waddr,
    input  logic [XLEN-1:0] wdata,
    input  logic [AW-1:0]   ra1,
    output logic [XLEN-1:0] rd1,
    input  logic [AW-1:0]   ra2,
    output logic [XLEN-1:0] rd2,
    input  logic [AW-1:0]   ra3,
    output logic [XLEN-1:0] rd3
);

    logic [XLEN-1:0] mem [NREG];

    // Reset clears the bank; otherwise write any entry but 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) mem[i] <= '0;
        end else if (we && waddr != '0) begin
            mem[waddr] <= wdata;
        end
    end

    assign rd1 = mem[ra1];
    assign rd2 = mem[ra2];
    assign rd3 = mem[ra3];

    // R2
    zero_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra3 == '0) |-> (rd3 == '0));

endmodule

// File: rtl/ixu_exec.sv
// Execute datapath: shared adder/subtractor with overflow detect, bitwise
// unit and barrel shifter. Combinational; expects operands already selected.
module ixu_exec
    import ixu_pkg::*;
#(
    parameter int XLEN = 32,
    localparam int SHW = $clog2(XLEN)
) (
    input  ctl_t            ctl,
    input  logic [XLEN-1:0] op_a,
    input  logic [XLEN-1:0] op_b,
    input  logic [SHW-1:0]  shamt_field,
    output logic [XLEN-1:0] result,
    output logic            ovf
);

    logic            is_sub;
    logic [XLEN-1:0] b_eff;
    logic [XLEN-1:0] sum;
    logic [SHW-1:0]  amt;

    // One adder serves add and subtract; B inverted plus carry-in for subtract.
    always_comb begin
        is_sub = (ctl.kind == K_SUB);
        b_eff  = is_sub ? ~op_b : op_b;
        sum    = op_a + b_eff + {{(XLEN-1){1'b0}}, is_sub};
        ovf    = (op_a[XLEN-1] == b_eff[XLEN-1]) && (sum[XLEN-1] != op_a[XLEN-1]);
    end

    // Shift amount comes from rs for variable forms, else from the field.
    assign amt = ctl.var_shamt ? op_a[SHW-1:0] : shamt_field;

    // Final result selection.
    always_comb begin
        case (ctl.kind)
            K_ADD, K_SUB: result = sum;
            K_AND:        result = op_a & op_b;
            K_OR:         result = op_a | op_b;
            K_XOR:        result = op_a ^ op_b;
            K_NOR:        result = ~(op_a | op_b);
            K_SLL:        result = op_b << amt;
            K_SRL:        result = op_b >> amt;
            K_SRA:        result = XLEN'($signed(op_b) >>> amt);
            K_LUI:        result = op_b << (XLEN / 2);
            default:      result = '0;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
// Integer ALU execute unit top: decodes one instruction per cycle, executes
// it against the register bank and writes back unless it faults. Assumes
// insn/insn_valid are known at every edge after reset.
module int_exec_unit
    import ixu_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int NREG = 32,
    localparam int AW  = $clog2(NREG),
    localparam int SHW = $clog2(XLEN),
    localparam int IMW = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            insn_valid,
    input  logic [31:0]     insn,
    output logic            exc_valid,
    output logic [1:0]      exc_code,
    input  logic [AW-1:0]   dbg_addr,
    output logic [XLEN-1:0] dbg_data
);

    ctl_t            ctl;
    logic [AW-1:0]   rs, rt, rd, dst;
    logic [XLEN-1:0] rs_val, rt_val, imm_ext, op_b, result;
    logic            ovf, wr_en;
    exc_t            exc_now;

    assign rs = insn[25:21];
    assign rt = insn[20:16];
    assign rd = insn[15:11];

    ixu_decode u_dec (
        .opcode (insn[31:26]),
        .funct  (insn[5:0]),
        .ctl    (ctl)
    );

    ixu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (wr_en),
        .waddr (dst),
        .wdata (result),
        .ra1   (rs),
        .rd1   (rs_val),
        .ra2   (rt),
        .rd2   (rt_val),
        .ra3   (dbg_addr),
        .rd3   (dbg_data)
    );

    // Immediate extension and second-operand select.
    always_comb begin
        imm_ext = ctl.imm_sext ? {{(XLEN-IMW){insn[IMW-1]}}, insn[IMW-1:0]}
                               : {{(XLEN-IMW){1'b0}}, insn[IMW-1:0]};
        op_b    = ctl.use_imm ? imm_ext : rt_val;
        dst     = ctl.dst_rt ? rt : rd;
    end

    ixu_exec #(.XLEN(XLEN)) u_exec (
        .ctl         (ctl),
        .op_a        (rs_val),
        .op_b        (op_b),
        .shamt_field (insn[6+SHW-1:6]),
        .result      (result),
        .ovf         (ovf)
    );

    // Fault classification and write enable.
    always_comb begin
        if (!ctl.legal)                exc_now = EXC_RSVD;
        else if (ctl.trap_ovf && ovf)  exc_now = EXC_OVF;
        else                           exc_now = EXC_NONE;
        wr_en = insn_valid && (exc_now == EXC_NONE);
    end

    // Register the exception pulse for the cycle after the edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exc_valid <= 1'b0;
            exc_code  <= EXC_NONE;
        end else begin
            exc_valid <= insn_valid && (exc_now != EXC_NONE);
            exc_code  <= insn_valid ? exc_now : EXC_NONE;
        end
    end

    // R4
    ovf_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.trap_ovf && ovf) |-> !wr_en);

    // R9
    rsvd_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.legal |-> !wr_en);

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !insn_valid |=> !exc_valid);

    // R11
    exc_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_code != 2'd0));

    // R6
    sra_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_valid && ctl.legal && ctl.kind == K_SRA) |-> (result[XLEN-1] == rt_val[XLEN-1]));

endmodule

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        insn_valid = 1'b0;
    logic [31:0] insn = '0;
    logic        exc_valid;
    logic [1:0]  exc_code;
    logic [4:0]  dbg_addr = '0;
    logic [31:0] dbg_data;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m [32];

    always #2.5 clk = ~clk;

    int_exec_unit u_dut (
        .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn(insn),
        .exc_valid(exc_valid), .exc_code(exc_code),
        .dbg_addr(dbg_addr), .dbg_data(dbg_data)
    );

    function automatic logic [31:0] enc_r(input int rs, rt, rd, sh, fn);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] enc_i(input int op, rs, rt, input logic [15:0] imm);
        return {6'(op), 5'(rs), 5'(rt), imm};
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Behavioural reference: what one instruction should do to the model.
    task automatic model_eval(input logic [31:0] w, output int code, output int dst,
                              output logic [31:0] val, output string tag);
        logic [5:0]  op = w[31:26];
        logic [5:0]  fn = w[5:0];
        int          rs = int'(w[25:21]);
        int          rt = int'(w[20:16]);
        int          sh = int'(w[10:6]);
        logic [31:0] a  = m[rs];
        logic [31:0] b  = m[rt];
        logic [31:0] si = {{16{w[15]}}, w[15:0]};
        logic [31:0] zi = {16'd0, w[15:0]};
        longint      s;
        code = 0; dst = int'(w[15:11]); val = 32'd0; tag = "R3";
        if (op == 6'd0) begin
            case (fn)
                6'h00: begin val = b << sh; tag = "R6"; end
                6'h02: begin val = b >> sh; tag = "R6"; end
                6'h03: begin val = $signed(b) >>> sh; tag = "R6"; end
                6'h04: begin val = b << a[4:0]; tag = "R7"; end
                6'h06: begin val = b >> a[4:0]; tag = "R7"; end
                6'h07: begin val = $signed(b) >>> a[4:0]; tag = "R7"; end
                6'h20, 6'h21: begin
                    val = a + b;
                    s = longint'($signed(a)) + longint'($signed(b));
                    if (fn == 6'h20 && (s > 64'sd2147483647 || s < -64'sd2147483648)) begin code = 1; tag = "R4"; end
                end
                6'h22, 6'h23: begin
                    val = a - b;
                    s = longint'($signed(a)) - longint'($signed(b));
                    if (fn == 6'h22 && (s > 64'sd2147483647 || s < -64'sd2147483648)) begin code = 1; tag = "R4"; end
                end
                6'h24: begin val = a & b; tag = "R5"; end
                6'h25: begin val = a | b; tag = "R5"; end
                6'h26: begin val = a ^ b; tag = "R5"; end
                6'h27: begin val = ~(a | b); tag = "R5"; end
                default: begin code = 2; tag = "R9"; end
            endcase
        end else begin
            dst = rt; tag = "R8";
            case (op)
                6'h08, 6'h09: begin
                    val = a + si;
                    s = longint'($signed(a)) + longint'($signed(si));
                    if (op == 6'h08 && (s > 64'sd2147483647 || s < -64'sd2147483648)) begin code = 1; tag = "R4"; end
                end
                6'h0C: val = a & zi;
                6'h0D: val = a | zi;
                6'h0E: val = a ^ zi;
                6'h0F: val = {w[15:0], 16'd0};
                default: begin code = 2; tag = "R9"; dst = int'(w[15:11]); end
            endcase
        end
    endtask

    // Drive one cycle, update the model and compare at the ports.
    task automatic issue(input logic v, input logic [31:0] w);
        int code, dst; logic [31:0] val; string tag;
        model_eval(w, code, dst, val, tag);
        if (!v) begin code = 0; tag = "R10"; end
        insn_valid = v; insn = w;
        @(posedge clk); #1;
        if (v && code == 0 && dst != 0) m[dst] = val;
        chk(exc_valid == (code != 0), {tag, "/R11 exc_valid"}, 32'(exc_valid), 32'(code != 0));
        chk(exc_code == 2'(code), {tag, " exc_code"}, 32'(exc_code), 32'(code));
        dbg_addr = 5'(dst); #0.2;
        chk(dbg_data == m[dst], {tag, (dst == 0) ? "/R2 reg" : " reg"}, dbg_data, m[dst]);
    endtask

    task automatic sweep(input string tag);
        insn_valid = 1'b0;
        for (int i = 0; i < 32; i++) begin
            dbg_addr = 5'(i); #0.05;
            chk(dbg_data == m[i], tag, dbg_data, m[i]);
        end
    endtask

    task automatic chk_reg(input int r, input logic [31:0] exp, input string tag);
        insn_valid = 1'b0;
        dbg_addr = 5'(r); #0.2;
        chk(dbg_data == exp, tag, dbg_data, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; insn_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 32; i++) m[i] = '0;
        chk(exc_valid == 1'b0, "R1 exc_valid", 32'(exc_valid), 0);
        sweep("R1 reset reg");
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // Operand setup
        issue(1, enc_i(6'h0F, 0, 1, 16'habcd));
        issue(1, enc_i(6'h0D, 1, 1, 16'h1234));
        issue(1, enc_i(6'h0F, 0, 2, 16'hffff));
        issue(1, enc_i(6'h09, 0, 3, 16'd16));
        issue(1, enc_i(6'h0F, 0, 4, 16'h7fff));
        issue(1, enc_i(6'h0D, 4, 4, 16'hffff));
        issue(1, enc_i(6'h09, 0, 5, 16'd1));
        issue(1, enc_i(6'h0F, 0, 6, 16'h8000));
        chk_reg(1, 32'habcd1234, "R8 lui+ori");
        // Constant and variable shifts
        issue(1, enc_r(0, 1, 7, 8, 6'h00)); chk_reg(7, 32'hcd123400, "R6 sll");
        issue(1, enc_r(0, 1, 7, 4, 6'h03)); chk_reg(7, 32'hfabcd123, "R6 sra");
        issue(1, enc_r(0, 1, 7, 4, 6'h02)); chk_reg(7, 32'h0abcd123, "R6 srl");
        issue(1, enc_r(3, 1, 7, 0, 6'h06)); chk_reg(7, 32'h0000abcd, "R7 srlv");
        issue(1, enc_r(3, 1, 7, 0, 6'h07)); chk_reg(7, 32'hffffabcd, "R7 srav");
        issue(1, enc_r(3, 1, 7, 0, 6'h04)); chk_reg(7, 32'h12340000, "R7 sllv");
        // Logic
        issue(1, enc_r(1, 2, 8, 0, 6'h24)); chk_reg(8, 32'habcd0000, "R5 and");
        issue(1, enc_r(1, 2, 8, 0, 6'h25)); chk_reg(8, 32'hffff1234, "R5 or");
        issue(1, enc_r(1, 2, 8, 0, 6'h26)); chk_reg(8, 32'h54321234, "R5 xor");
        issue(1, enc_r(1, 2, 8, 0, 6'h27)); chk_reg(8, 32'h0000edcb, "R5 nor");
        // Overflow corners
        issue(1, enc_r(4, 5, 8, 0, 6'h20)); chk_reg(8, 32'h0000edcb, "R4 add ovf no write");
        issue(0, enc_r(4, 5, 8, 0, 6'h20)); // pulse must drop (R11)
        issue(1, enc_r(4, 5, 9, 0, 6'h21)); chk_reg(9, 32'h80000000, "R3 addu wrap");
        issue(1, enc_r(6, 5, 9, 0, 6'h22)); chk_reg(9, 32'h80000000, "R4 sub ovf no write");
        issue(1, enc_r(6, 5, 9, 0, 6'h22));
        issue(1, enc_r(6, 5, 9, 0, 6'h23)); chk_reg(9, 32'h7fffffff, "R3 subu wrap");
        issue(1, enc_i(6'h08, 4, 10, 16'd1)); chk_reg(10, 32'h0, "R4 addi ovf no write");
        issue(1, enc_i(6'h09, 1, 10, 16'hffff)); chk_reg(10, 32'habcd1233, "R8 addiu sext");
        issue(1, enc_i(6'h0C, 1, 11, 16'hf0f0)); chk_reg(11, 32'h00001030, "R8 andi zext");
        issue(1, enc_i(6'h09, 5, 0, 16'd5)); chk_reg(0, 32'h0, "R2 r0 write");
        // Reserved encodings
        issue(1, enc_i(6'h3f, 1, 12, 16'h1234)); chk_reg(12, 32'h0, "R9 opcode");
        issue(1, enc_r(1, 2, 12, 0, 6'h01)); chk_reg(12, 32'h0, "R9 funct");
        issue(0, enc_r(1, 2, 12, 0, 6'h25)); chk_reg(12, 32'h0, "R10 idle");
        // Random mix
        for (int n = 0; n < 600; n++) begin
            int k = $urandom_range(0, 21);
            int ra = $urandom_range(0, 7);
            int rb = $urandom_range(0, 7);
            int rc = $urandom_range(0, 7);
            int sa = $urandom_range(0, 31);
            logic [15:0] im = 16'($urandom);
            logic [31:0] w;
            case (k)
                0: w = enc_r(ra, rb, rc, sa, 6'h00);
                1: w = enc_r(ra, rb, rc, sa, 6'h02);
                2: w = enc_r(ra, rb, rc, sa, 6'h03);
                3: w = enc_r(ra, rb, rc, 0, 6'h04);
                4: w = enc_r(ra, rb, rc, 0, 6'h06);
                5: w = enc_r(ra, rb, rc, 0, 6'h07);
                6: w = enc_r(ra, rb, rc, 0, 6'h20);
                7: w = enc_r(ra, rb, rc, 0, 6'h21);
                8: w = enc_r(ra, rb, rc, 0, 6'h22);
                9: w = enc_r(ra, rb, rc, 0, 6'h23);
                10: w = enc_r(ra, rb, rc, 0, 6'h24);
                11: w = enc_r(ra, rb, rc, 0, 6'h25);
                12: w = enc_r(ra, rb, rc, 0, 6'h26);
                13: w = enc_r(ra, rb, rc, 0, 6'h27);
                14: w = enc_i(6'h08, ra, rb, im);
                15: w = enc_i(6'h09, ra, rb, im);
                16: w = enc_i(6'h0C, ra, rb, im);
                17: w = enc_i(6'h0D, ra, rb, im);
                18: w = enc_i(6'h0E, ra, rb, im);
                19: w = enc_i(6'h0F, ra, rb, im);
                default: w = $urandom;
            endcase
            issue((n % 9) != 8, w);
        end
        sweep("R3 final state");
        // Reset in mid-run clears everything
        do_reset();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule